// File: doc/BRIEF.md
# Profiling Sample Record Filter

This block sits at the end of a statistical profiling pipeline. It decides whether each finished sample record is kept and forwarded toward the memory writer, or dropped. A pulse on `sample_start` marks the cycle in which an operation is picked for profiling. From that cycle an internal timer counts the cycles until the record completes. The count covers the whole time since selection, not only the time the operation spent executing.

When `rec_valid` pulses, the block looks at three things: the record's operation class, its event bit vector and the measured latency. It compares them with three programmed criteria: a set of class enables, a mask of required events, and a minimum latency. One cycle later it reports the verdict on `dec_keep` together with a one-cycle `dec_valid` pulse, and it presents the measured latency. A dropped record ends the handling of that sample.

Only one sampled operation can be in flight. A new selection that arrives while a record is still outstanding collides with it and is dropped.

Top module: `rec_filter`

## Requirements
- R1: While reset is asserted, and after it is released with no other activity, `dec_valid` and `dec_keep` are 0 and `dec_latency` is 0.
- R2: `rec_type` is encoded as 0 other, 1 branch, 2 load and 3 store. The enables `cfg_keep_branch`, `cfg_keep_load` and `cfg_keep_store` pass records of their own class. If several enables are set, a record passes when it matches any enabled class. If no enable is set, every class passes.
- R3: A record passes the event test only when every bit set in `cfg_event_mask` is also set in `rec_events`. Bit 1 means the operation retired, bit 7 means a mispredicted branch, and bit 11 means a misaligned access.
- R4: A record whose measured latency is below `cfg_min_lat` is discarded. A latency equal to or above the threshold passes this test.
- R5: The latency is the number of clock cycles from the cycle in which `sample_start` was high to the cycle in which `rec_valid` is high. A record that completes N cycles after selection reports N on `dec_latency`.
- R6: The latency is 12 bits wide. Once it reaches 4095 it stays there and does not wrap.
- R7: A `sample_start` that arrives while a sample is outstanding and no record completes in that cycle is ignored, and the running count continues. A `sample_start` in the same cycle as `rec_valid` begins a new sample.
- R8: `dec_valid` is high for exactly one cycle, in the cycle after `rec_valid`. `dec_keep` is 1 only in that cycle and only when all three tests pass; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_start | input | 1 | Operation selected for sampling in this cycle |
| rec_valid | input | 1 | Sampled operation's record completes in this cycle |
| rec_type | input | 2 | Operation class of the completing record |
| rec_events | input | 16 | Events observed for the completing record |
| cfg_keep_branch | input | 1 | Pass branch records |
| cfg_keep_load | input | 1 | Pass load records |
| cfg_keep_store | input | 1 | Pass store records |
| cfg_event_mask | input | 16 | Events that must all be present |
| cfg_min_lat | input | 12 | Minimum latency for a kept record |
| dec_valid | output | 1 | Verdict valid, one-cycle pulse |
| dec_keep | output | 1 | Keep (1) or discard (0) |
| dec_latency | output | 12 | Measured latency of the judged record |

## Verification
The bench places latency exactly one below, equal to, and one above the threshold. An off-by-one in the comparison or in the counter's start value would flip one of those verdicts or shift the reported count. It runs a record past 4095 cycles, where a wrapping counter would report a small value and be discarded by a high threshold. It raises a second selection partway through an outstanding sample; a design that restarted the timer would report a latency that is too short. The event-mask vectors give a record only some of the required bits, which an any-bit match would wrongly keep. The class vectors combine several enables and also set none, which catches an AND-style match or a default that blocks everything.

// File: rtl/rf_pkg.sv
package rf_pkg;

  typedef enum logic [1:0] {
    OP_OTHER  = 2'd0,
    OP_BRANCH = 2'd1,
    OP_LOAD   = 2'd2,
    OP_STORE  = 2'd3
  } op_class_e;

  // Event bit positions with fixed meaning
  localparam int unsigned EV_RETIRED    = 1;
  localparam int unsigned EV_MISPREDICT = 7;
  localparam int unsigned EV_MISALIGNED = 11;

endpackage

// File: rtl/rf_latency_timer.sv
module rf_latency_timer #(
  parameter int unsigned LAT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             done_i,
  output logic [LAT_W-1:0] lat_o
);

  localparam logic [LAT_W-1:0] LAT_MAX = '1;
  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

  logic             busy_q, busy_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             accept;
  logic             cnt_en;

  // A new selection is taken only when nothing is outstanding or the
  // outstanding record completes in this same cycle (R7).
  assign accept = start_i && (!busy_q || done_i);
  assign cnt_en = accept || (busy_q && !done_i && (cnt_q != LAT_MAX));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = LAT_ONE;
    end else if (done_i) begin
      busy_d = 1'b0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + LAT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign lat_o = cnt_q;

  // R5 / R7: an outstanding sample keeps counting by one, whatever start_i does
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_i && (cnt_q != LAT_MAX)) |=> (cnt_q == LAT_W'($past(cnt_q) + LAT_ONE)));

  // R6: the count stays at its ceiling
  a_r6_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_i && (cnt_q == LAT_MAX)) |=> (cnt_q == LAT_MAX));

endmodule

// File: rtl/rf_criteria.sv
module rf_criteria
  import rf_pkg::*;
#(
  parameter int unsigned EV_W  = 16,
  parameter int unsigned LAT_W = 12
) (
  input  op_class_e        op_i,
  input  logic [EV_W-1:0]  events_i,
  input  logic             en_branch_i,
  input  logic             en_load_i,
  input  logic             en_store_i,
  input  logic [EV_W-1:0]  ev_mask_i,
  input  logic [LAT_W-1:0] min_lat_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             pass_o
);

  logic any_en;
  logic class_ok;
  logic events_ok;
  logic lat_ok;

  always_comb begin
    any_en   = en_branch_i | en_load_i | en_store_i;
    class_ok = !any_en
             | (en_branch_i && (op_i == OP_BRANCH))
             | (en_load_i   && (op_i == OP_LOAD))
             | (en_store_i  && (op_i == OP_STORE));
    events_ok = ((events_i & ev_mask_i) == ev_mask_i);
    lat_ok    = (lat_i >= min_lat_i);
    pass_o    = class_ok && events_ok && lat_ok;
  end

endmodule

// File: rtl/rec_filter.sv
module rec_filter
  import rf_pkg::*;
#(
  parameter int unsigned EV_W  = 16,
  parameter int unsigned LAT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_start,
  input  logic             rec_valid,
  input  logic [1:0]       rec_type,
  input  logic [EV_W-1:0]  rec_events,
  input  logic             cfg_keep_branch,
  input  logic             cfg_keep_load,
  input  logic             cfg_keep_store,
  input  logic [EV_W-1:0]  cfg_event_mask,
  input  logic [LAT_W-1:0] cfg_min_lat,
  output logic             dec_valid,
  output logic             dec_keep,
  output logic [LAT_W-1:0] dec_latency
);

  logic [LAT_W-1:0] lat_now;
  logic             pass;

  logic             vld_q, vld_d;
  logic             keep_q, keep_d;
  logic [LAT_W-1:0] lat_q;

  rf_latency_timer #(.LAT_W(LAT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (sample_start),
    .done_i  (rec_valid),
    .lat_o   (lat_now)
  );

  rf_criteria #(.EV_W(EV_W), .LAT_W(LAT_W)) u_criteria (
    .op_i        (op_class_e'(rec_type)),
    .events_i    (rec_events),
    .en_branch_i (cfg_keep_branch),
    .en_load_i   (cfg_keep_load),
    .en_store_i  (cfg_keep_store),
    .ev_mask_i   (cfg_event_mask),
    .min_lat_i   (cfg_min_lat),
    .lat_i       (lat_now),
    .pass_o      (pass)
  );

  always_comb begin
    vld_d  = rec_valid;
    keep_d = rec_valid && pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      keep_q <= 1'b0;
      lat_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      keep_q <= keep_d;
      if (rec_valid) lat_q <= lat_now;
    end
  end

  assign dec_valid   = vld_q;
  assign dec_keep    = keep_q;
  assign dec_latency = lat_q;

  // R8: keep is never shown without a valid verdict
  a_r8_keep_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_keep);

  // R4: a kept record met the threshold in force when it completed
  a_r4_kept_meets_min: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_keep) |-> (dec_latency >= $past(cfg_min_lat)));

  // R3: a kept record carried every required event
  a_r3_kept_has_events: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_keep) |->
      (($past(rec_events) & $past(cfg_event_mask)) == $past(cfg_event_mask)));

  // R2: with only the branch enable set, a kept record is a branch
  a_r2_branch_only: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_keep && $past(cfg_keep_branch) && !$past(cfg_keep_load) && !$past(cfg_keep_store))
      |-> ($past(rec_type) == 2'd1));

endmodule

// File: tb/test_rec_filter.sv
`timescale 1ns/1ps
module test_rec_filter;

  logic        clk;
  logic        rst_n;
  logic        sample_start;
  logic        rec_valid;
  logic [1:0]  rec_type;
  logic [15:0] rec_events;
  logic        cfg_keep_branch, cfg_keep_load, cfg_keep_store;
  logic [15:0] cfg_event_mask;
  logic [11:0] cfg_min_lat;
  logic        dec_valid, dec_keep;
  logic [11:0] dec_latency;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  rec_filter i_rec_filter (
    .clk(clk), .rst_n(rst_n), .sample_start(sample_start), .rec_valid(rec_valid),
    .rec_type(rec_type), .rec_events(rec_events),
    .cfg_keep_branch(cfg_keep_branch), .cfg_keep_load(cfg_keep_load),
    .cfg_keep_store(cfg_keep_store), .cfg_event_mask(cfg_event_mask),
    .cfg_min_lat(cfg_min_lat), .dec_valid(dec_valid), .dec_keep(dec_keep),
    .dec_latency(dec_latency)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] ev;
    logic [15:0] mask;
    logic [2:0]  en;     // {branch, load, store}
    logic [11:0] min_lat;
    logic [15:0] dly;
    logic        keep;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{2'd2, 16'h0000, 16'h0000, 3'b000, 12'd0,  16'd5,  1'b1}, // R2 none enabled
    '{2'd2, 16'h0000, 16'h0000, 3'b100, 12'd0,  16'd5,  1'b0}, // R2 load vs branch-only
    '{2'd1, 16'h0000, 16'h0000, 3'b100, 12'd0,  16'd4,  1'b1}, // R2 branch-only
    '{2'd3, 16'h0000, 16'h0000, 3'b011, 12'd0,  16'd6,  1'b1}, // R2 store, ld+st
    '{2'd0, 16'h0000, 16'h0000, 3'b011, 12'd0,  16'd6,  1'b0}, // R2 other, ld+st
    '{2'd2, 16'h0003, 16'h0002, 3'b000, 12'd0,  16'd3,  1'b1}, // R3 retired present
    '{2'd2, 16'h0001, 16'h0002, 3'b000, 12'd0,  16'd3,  1'b0}, // R3 retired absent
    '{2'd1, 16'h0082, 16'h0880, 3'b000, 12'd0,  16'd3,  1'b0}, // R3 only part of mask
    '{2'd1, 16'h0082, 16'h0080, 3'b100, 12'd0,  16'd3,  1'b1}, // R3 mispredict
    '{2'd3, 16'h0800, 16'h0800, 3'b001, 12'd0,  16'd2,  1'b1}, // R3 misaligned
    '{2'd2, 16'h0000, 16'h0000, 3'b000, 12'd10, 16'd9,  1'b0}, // R4 below
    '{2'd2, 16'h0000, 16'h0000, 3'b000, 12'd10, 16'd10, 1'b1}, // R4 equal
    '{2'd2, 16'h0000, 16'h0000, 3'b000, 12'd10, 16'd11, 1'b1}  // R4 above
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] en, input logic [15:0] mask, input logic [11:0] ml);
    {cfg_keep_branch, cfg_keep_load, cfg_keep_store} = en;
    cfg_event_mask = mask;
    cfg_min_lat    = ml;
  endtask

  // Selects at one negedge, completes dly cycles later; leaves time at the
  // negedge where the verdict is visible.
  task automatic run_rec(input logic [1:0] op, input logic [15:0] ev, input int dly);
    @(negedge clk) sample_start = 1'b1;
    for (int k = 0; k < dly; k++) begin
      @(negedge clk) sample_start = 1'b0;
    end
    rec_valid = 1'b1; rec_type = op; rec_events = ev;
    @(negedge clk) rec_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; sample_start = 1'b0; rec_valid = 1'b0;
    rec_type = 2'd0; rec_events = '0;
    set_cfg(3'b000, 16'h0000, 12'd0);
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(dec_valid), 0);
    check("R1 keep in reset", int'(dec_keep), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", int'(dec_valid), 0);
    check("R1 latency after reset", int'(dec_latency), 0);

    for (int i = 0; i < NV; i++) begin
      set_cfg(TBL[i].en, TBL[i].mask, TBL[i].min_lat);
      run_rec(TBL[i].op, TBL[i].ev, int'(TBL[i].dly));
      check($sformatf("R8 vector %0d valid", i), int'(dec_valid), 1);
      check($sformatf("R2/R3/R4 vector %0d keep", i), int'(dec_keep), int'(TBL[i].keep));
      check($sformatf("R5 vector %0d latency", i), int'(dec_latency), int'(TBL[i].dly));
      @(negedge clk);
      check($sformatf("R8 vector %0d single pulse", i), int'(dec_valid), 0);
      check($sformatf("R8 vector %0d keep drops", i), int'(dec_keep), 0);
    end

    // R6: saturation past 4095 with the highest threshold
    set_cfg(3'b000, 16'h0000, 12'd4095);
    run_rec(2'd2, 16'h0000, 4200);
    check("R6 saturated latency", int'(dec_latency), 4095);
    check("R6 keep at ceiling", int'(dec_keep), 1);

    // R7: a second selection while outstanding is ignored
    set_cfg(3'b000, 16'h0000, 12'd0);
    @(negedge clk) sample_start = 1'b1;
    @(negedge clk) sample_start = 1'b0;
    @(negedge clk);
    @(negedge clk) sample_start = 1'b1;   // collision, 3 cycles in
    @(negedge clk) sample_start = 1'b0;
    repeat (5) @(negedge clk);            // now 9 cycles after selection
    rec_valid = 1'b1;
    @(negedge clk) rec_valid = 1'b0;
    check("R7 collision ignored latency", int'(dec_latency), 9);

    // R7: start in the completion cycle begins a fresh sample
    @(negedge clk) sample_start = 1'b1;
    @(negedge clk) sample_start = 1'b0;
    @(negedge clk);
    rec_valid = 1'b1; sample_start = 1'b1;  // completes at 2, restarts
    @(negedge clk) rec_valid = 1'b0; sample_start = 1'b0;
    check("R7 first record latency", int'(dec_latency), 2);
    repeat (3) @(negedge clk);              // 4 cycles after restart
    rec_valid = 1'b1;
    @(negedge clk) rec_valid = 1'b0;
    check("R7 restarted latency", int'(dec_latency), 4);

    // R1: asynchronous reset clears a pending verdict
    run_rec(2'd1, 16'h0000, 2);
    #3 rst_n = 1'b0;
    #2 check("R1 async clear valid", int'(dec_valid), 0);
    check("R1 async clear latency", int'(dec_latency), 0);
    @(negedge clk) rst_n = 1'b1;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule